// File: doc/BRIEF.md
# Access Permission Check and Fault Logger

This block sits next to a page-table walker. Once the walker reaches the final page entry, the block receives four things: the entry's 3-bit permission code, its modified flag, the kind of access and the privilege level. From these it decides, in the same cycle, whether the access faults and which fault it is. It also decides whether a translation cache may hold the page as writable.

When the walker reports the outcome of an access, a faulting result is recorded in two registers. The fault status register holds the access index, the fault type and a valid flag. It also shows an overflow when a fault arrives before software has read the previous one. The fault address register holds the virtual address. A trap request goes out unless the no-fault mode is set or traps are disabled. Reading the status register through the read strobe clears it.

Top module: `access_fault_logger`

## Requirements
- R1: The access index is {acc_write, acc_kind1, acc_super}. It appears in fsr_q[7:5] of a logged fault, the fault type in fsr_q[3:2], and bit 1 is set for every logged fault.
- R2: Reads (index 0 or 1). User reads give fault 3 (privilege) for codes 6 and 7, fault 2 (protection) for code 4, and 0 otherwise. Supervisor reads fault only on code 4, with type 2.
- R3: Other accesses are allowed only by these codes. Execute (acc_kind1=1, no write): user codes 2, 3, 4; supervisor codes 2, 3, 4, 6, 7. Write: user codes 1, 3; supervisor codes 1, 3, 5, 7. Write with acc_kind1=1: user code 3; supervisor codes 3, 7. A user access to code 6 or 7 gives type 3. Any other disallowed access gives type 2.
- R4: wr_grant is 1 only when three things hold: page_dirty is 1, the access does not fault, and the code permits writing at the current privilege (supervisor: 1, 3, 5, 7; user: 1, 3).
- R5: A faulting report writes fsr_q on the next edge. If fsr_q was nonzero, the new value is 1 | (index<<5) | (type<<2) | 2. If fsr_q was zero, the new value is (index<<5) | (type<<2) | 2.
- R6: A faulting report loads rpt_vaddr into far_q on the next edge.
- R7: trap_req = rpt_valid with a nonzero fault type, while no_fault_mode is 0 and traps_on is 1. Either control alone suppresses it.
- R8: fsr_rd without a faulting report clears fsr_q to zero on the next edge. A faulting report in the same cycle takes precedence.
- R9: After reset, fsr_q and far_q are zero. A report with fault type 0 leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_write | input | 1 | Access is a write |
| acc_kind1 | input | 1 | Bit 1 of the access type (execute class) |
| acc_super | input | 1 | 1 = supervisor, 0 = user |
| perm_code | input | 3 | Permission code of the final page entry |
| page_dirty | input | 1 | Modified flag of the page entry |
| fault_kind | output | 2 | 0 none, 2 protection, 3 privilege |
| wr_grant | output | 1 | Page may be cached as writable |
| rpt_valid | input | 1 | Access outcome report strobe |
| rpt_vaddr | input | ADDR_W | Virtual address of the reported access |
| no_fault_mode | input | 1 | Suppress trap requests |
| traps_on | input | 1 | Traps enabled |
| trap_req | output | 1 | Trap request for a faulting report |
| fsr_rd | input | 1 | Status register read strobe (clears it) |
| fsr_q | output | 8 | Fault status register |
| far_q | output | ADDR_W | Fault address register |

## Verification
The bench builds the block with ADDR_W at its default of 32. At that width the address register can be loaded with values whose top bit is set, and a full-width address can be checked after an overflow. The vector table covers every access-index row against representative permission codes, including the supervisor-only codes 6 and 7. The directed part then checks the sequences of status-register updates: first fault, overflow, clear-on-read, and a fault landing in the same cycle as a read.

// File: rtl/access_fault_logger.sv
module access_fault_logger #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_write,
  input  logic              acc_kind1,
  input  logic              acc_super,
  input  logic [2:0]        perm_code,
  input  logic              page_dirty,
  output logic [1:0]        fault_kind,
  output logic              wr_grant,
  input  logic              rpt_valid,
  input  logic [ADDR_W-1:0] rpt_vaddr,
  input  logic              no_fault_mode,
  input  logic              traps_on,
  output logic              trap_req,
  input  logic              fsr_rd,
  output logic [7:0]        fsr_q,
  output logic [ADDR_W-1:0] far_q
);
  // per-code permission masks, bit n = code n
  localparam logic [7:0] USR_R = 8'b0010_1111;
  localparam logic [7:0] USR_W = 8'b0000_1010;
  localparam logic [7:0] USR_X = 8'b0001_1100;
  localparam logic [7:0] SUP_R = 8'b1110_1111;
  localparam logic [7:0] SUP_W = 8'b1010_1010;
  localparam logic [7:0] SUP_X = 8'b1101_1100;

  logic [2:0] acc_idx;
  logic       can_r, can_w, can_x, ok;
  logic       log_en;

  assign acc_idx = {acc_write, acc_kind1, acc_super};
  assign can_r   = acc_super ? SUP_R[perm_code] : USR_R[perm_code];
  assign can_w   = acc_super ? SUP_W[perm_code] : USR_W[perm_code];
  assign can_x   = acc_super ? SUP_X[perm_code] : USR_X[perm_code];

  always_comb begin
    unique case ({acc_write, acc_kind1})
      2'b00:   ok = can_r;
      2'b01:   ok = can_x;
      2'b10:   ok = can_w;
      default: ok = can_w & can_x;
    endcase
    if (ok)                              fault_kind = 2'd0;
    else if (!acc_super && perm_code[2] && perm_code[1]) fault_kind = 2'd3;
    else                                 fault_kind = 2'd2;
  end

  assign wr_grant = page_dirty & ok & can_w;
  assign log_en   = rpt_valid & (fault_kind != 2'd0);
  assign trap_req = log_en & ~no_fault_mode & traps_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (log_en) begin
      fsr_q <= {acc_idx, 1'b0, fault_kind, 1'b1, (fsr_q != 8'd0)};
      far_q <= rpt_vaddr;
    end else if (fsr_rd) begin
      fsr_q <= '0;
    end
  end
endmodule

module access_fault_logger_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              page_dirty,
  input logic [1:0]        fault_kind,
  input logic              wr_grant,
  input logic              rpt_valid,
  input logic [ADDR_W-1:0] rpt_vaddr,
  input logic              no_fault_mode,
  input logic              traps_on,
  input logic              trap_req,
  input logic              fsr_rd,
  input logic [7:0]        fsr_q,
  input logic [ADDR_W-1:0] far_q
);
  logic hit;
  assign hit = rpt_valid && fault_kind != 2'd0;

  AST_GRANT_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) !page_dirty |-> !wr_grant); // R4
  AST_GRANT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) fault_kind != 2'd0 |-> !wr_grant); // R4
  AST_FSR_VALID_BIT: assert property (@(posedge clk) disable iff (!rst_n) hit |=> fsr_q[1]); // R1
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (hit && fsr_q != 8'd0) |=> fsr_q[0]); // R5
  AST_FAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) hit |=> far_q == $past(rpt_vaddr)); // R6
  AST_TRAP_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (no_fault_mode || !traps_on) |-> !trap_req); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (fsr_rd && !hit) |=> fsr_q == 8'd0); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!fsr_rd && !hit) |=> ($stable(fsr_q) && $stable(far_q))); // R9
endmodule

bind access_fault_logger access_fault_logger_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .page_dirty(page_dirty), .fault_kind(fault_kind),
  .wr_grant(wr_grant), .rpt_valid(rpt_valid), .rpt_vaddr(rpt_vaddr),
  .no_fault_mode(no_fault_mode), .traps_on(traps_on), .trap_req(trap_req),
  .fsr_rd(fsr_rd), .fsr_q(fsr_q), .far_q(far_q)
);

// File: tb/test_access_fault_logger.sv
module test_access_fault_logger;
  localparam int ADDR_W = 32;
  logic clk = 0, rst_n = 0;
  logic acc_write = 0, acc_kind1 = 0, acc_super = 0, page_dirty = 0;
  logic [2:0] perm_code = 0;
  logic [1:0] fault_kind;
  logic wr_grant, trap_req;
  logic rpt_valid = 0, no_fault_mode = 0, traps_on = 1, fsr_rd = 0;
  logic [ADDR_W-1:0] rpt_vaddr = '0, far_q;
  logic [7:0] fsr_q;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  access_fault_logger #(.ADDR_W(ADDR_W)) i_access_fault_logger (.*);

  // {write, kind1, super, code[2:0], dirty, type[1:0], grant}
  localparam int NV = 19;
  localparam logic [9:0] VEC [NV] = '{
    10'b000_000_1_00_0, // R2 user read code0
    10'b000_100_0_10_0, // R2 user read code4
    10'b000_110_0_11_0, // R2 user read code6
    10'b001_100_0_10_0, // R2 sup read code4
    10'b001_111_1_00_1, // R2/R4 sup read code7 dirty
    10'b010_101_0_10_0, // R3 user exec code5
    10'b010_100_1_00_0, // R3 user exec code4
    10'b011_110_0_00_0, // R3 sup exec code6
    10'b011_001_0_10_0, // R3 sup exec code1
    10'b100_001_1_00_1, // R3/R4 user write code1
    10'b100_101_1_10_0, // R3 user write code5
    10'b101_101_1_00_1, // R4 sup write code5 dirty
    10'b101_101_0_00_0, // R4 sup write code5 clean
    10'b101_110_0_10_0, // R3 sup write code6
    10'b110_001_0_10_0, // R3 user wx code1
    10'b110_011_1_00_1, // R3 user wx code3
    10'b111_111_1_00_1, // R3 sup wx code7
    10'b110_111_0_11_0, // R3 user wx code7
    10'b111_101_0_10_0  // R3 sup wx code5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_acc(input logic [2:0] idx, input logic [2:0] code);
    {acc_write, acc_kind1, acc_super} = idx;
    perm_code = code;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R9 reset fsr", 32'(fsr_q), 0);
    chk("R9 reset far", far_q, 0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {acc_write, acc_kind1, acc_super, perm_code, page_dirty} = VEC[i][9:3];
      #1;
      chk($sformatf("R2/R3 vec%0d type", i), 32'(fault_kind), 32'(VEC[i][2:1]));
      chk($sformatf("R4 vec%0d grant", i), 32'(wr_grant), 32'(VEC[i][0]));
    end
    // non-faulting report leaves registers alone
    @(negedge clk); set_acc(3'b001, 3'd0); rpt_valid = 1; rpt_vaddr = 32'h1234_5678;
    @(negedge clk); rpt_valid = 0;
    chk("R9 no-fault report fsr", 32'(fsr_q), 0);
    chk("R9 no-fault report far", far_q, 0);
    // first fault: user read code6 -> idx0 type3
    set_acc(3'b000, 3'd6); rpt_valid = 1; rpt_vaddr = 32'hFFFF_F004; #1;
    chk("R7 trap on", 32'(trap_req), 1);
    @(negedge clk); rpt_valid = 0;
    chk("R5 first fault", 32'(fsr_q), 32'h0E);
    chk("R6 far", far_q, 32'hFFFF_F004);
    // second fault: sup write code0 -> idx5 type2, overflow
    set_acc(3'b101, 3'd0); rpt_valid = 1; rpt_vaddr = 32'h8000_0100;
    no_fault_mode = 1; #1;
    chk("R7 no-fault mode masks", 32'(trap_req), 0);
    @(negedge clk); rpt_valid = 0; no_fault_mode = 0;
    chk("R1 R5 overflow", 32'(fsr_q), 32'hAB);
    chk("R6 far second", far_q, 32'h8000_0100);
    // read clears
    fsr_rd = 1;
    @(negedge clk); fsr_rd = 0;
    chk("R8 clear on read", 32'(fsr_q), 0);
    chk("R8 far kept", far_q, 32'h8000_0100);
    // fault with read same cycle: user exec code7 -> idx2 type3
    set_acc(3'b010, 3'd7); rpt_valid = 1; fsr_rd = 1; traps_on = 0; rpt_vaddr = 32'h0000_0ABC; #1;
    chk("R7 traps off masks", 32'(trap_req), 0);
    @(negedge clk); rpt_valid = 0; fsr_rd = 0; traps_on = 1;
    chk("R8 R1 fault beats read", 32'(fsr_q), 32'h4E);
    chk("R6 far third", far_q, 32'h0000_0ABC);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule